// File: doc/BRIEF.md
# Burst Serial Port with Byte Queue

This block is one channel of a clocked, byte-wide serial link backed by a small on-chip byte queue. Software loads bytes into the queue through a valid/ready write stream, picks a burst length of one to eight bytes, and issues a start pulse. The channel then shifts that many bytes out of the queue, most significant bit first. No software action is needed between bytes. Each byte received during a slot is written back into the queue entry whose byte was just sent. When the burst ends, the queue therefore holds the received data, in the same order, and software drains it through a valid/ready read stream.

The serial clock comes from one of two sources. The channel can generate it internally, with a 16-cycle period split evenly into a high phase and a low phase. It can also follow a clock supplied on the clock input pin. An optional select-gated mode makes the channel drive its clock and data outputs only while the active-low select input is low, and shifting pauses while that input is high. A single-cycle completion pulse marks the end of each burst.

Back-pressure rules:
- The write stream accepts a byte only while the channel is idle and the queue holds fewer bytes than its depth.
- The read stream offers the head byte only while the channel is idle, no start is being presented, and the queue is not empty.
- A byte moves only in a cycle where valid and ready are both high.

Top module: `burst_serial_port`

## Requirements
- R1: `wr_ready` is high exactly when the channel is idle and fewer than DEPTH bytes are queued. A byte is stored when `wr_valid` and `wr_ready` are both high. With 8 bytes queued, `wr_ready` is low.
- R2: `rd_valid` is high only when the channel is idle, `start` is low and the queue is not empty. `rd_data` presents bytes in queue order, and a byte is removed on `rd_valid && rd_ready`. `rd_valid` is low during a burst.
- R3: A start accepted while idle transmits the number of bytes given by `cfg_count`, beginning at the queue head. The count code 0 means 8, and codes 1 to 7 mean themselves. Bits leave most significant first, and `so` changes only after a falling edge of the serial clock.
- R4: `si` is sampled on each rising edge of the serial clock. After 8 rising edges, the assembled byte replaces the queue entry just transmitted. The number of queued bytes is unchanged by a burst, so entries beyond the burst keep their original contents.
- R5: With the internal clock, `sck_o` has a period of 16 system cycles, with 8 high and 8 low. It idles high whenever no burst is running, and `sck_oe` is high when select-gated mode is off.
- R6: `done_irq` is high for exactly one cycle. With the internal clock, it is first seen 128×N cycles after the clock edge that accepts a start for N bytes. `busy` is low in that same cycle.
- R7: With `cfg_ext_clk`=1, `sck_oe` is low and shifting follows the edges of `sck_i`. `sck_i` and `si` each pass through a two-flop synchronizer before their edges are used.
- R8: With `cfg_cs_mode`=1, `sck_oe` and `so_oe` are high only while the synchronized `cs_n` is low. While `cs_n` is high, no shifting takes place and `sck_o` stays high.
- R9: A `start` pulse, or a change of `cfg_count`, during a burst has no effect on that burst's length or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| wr_data | input | DW | Byte to queue |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| rd_data | output | DW | Head byte of queue |
| cfg_count | input | log2(DEPTH) | Burst length code, 0 means DEPTH |
| cfg_ext_clk | input | 1 | 1 = follow `sck_i`, 0 = generate the clock |
| cfg_cs_mode | input | 1 | Enable select-gated drive and shifting |
| start | input | 1 | Burst start strobe |
| busy | output | 1 | Burst in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| sck_i | input | 1 | External serial clock |
| sck_o | output | 1 | Internal serial clock |
| sck_oe | output | 1 | Output enable for `sck_o` |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| cs_n | input | 1 | Active-low select |

## Verification
The bench builds the block with its defaults: DW=8, DEPTH=8 and an 8-cycle half period. That makes every burst length from 1 to 8 reachable, including the count code 0 that wraps to 8. With every burst length covered, the exact 128×N completion time can be compared for each length. A byte pattern derived arithmetically from the burst length is loaded for each run, and the bench acts as the far end of the link. It can therefore check the transmitted bytes, the received write-back and the untouched tail entries for every length. Externally clocked bursts and select-gated bursts run on the same small configuration.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic {
    SCK_INTERNAL = 1'b0,
    SCK_EXTERNAL = 1'b1
  } sck_src_e;

  typedef struct packed {
    logic fall;
    logic rise;
  } sck_edge_t;
endpackage

// File: rtl/sbp_fifo.sv
module sbp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [DW-1:0] push_data,
  input  logic          pop_en,
  output logic [DW-1:0] head_data,
  output logic [IW-1:0] head_idx,
  output logic [LW-1:0] level,
  input  logic [IW-1:0] acc_idx,
  output logic [DW-1:0] acc_data,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic [DW-1:0] upd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] tail;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // per-entry storage: pushes and burst write-backs never coincide
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 mem[i] <= '0;
      else if (push_en && tail == IW'(i))         mem[i] <= push_data;
      else if (upd_en && upd_idx == IW'(i))       mem[i] <= upd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_idx <= '0;
      tail     <= '0;
      level    <= '0;
    end else begin
      if (push_en) tail     <= step(tail);
      if (pop_en)  head_idx <= step(head_idx);
      case ({push_en, pop_en})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head_data = mem[head_idx];
  assign acc_data  = mem[acc_idx];

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> level < LW'(DEPTH));
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> level != '0);
  assert_level_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !push_en && !pop_en) |=> $stable(level));
endmodule

// File: rtl/sbp_sck_gen.sv
module sbp_sck_gen
  import sbp_pkg::*;
#(
  parameter int HALF = 8,
  localparam int CW  = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  sck_src_e  src,
  input  logic      gate,
  input  logic      sck_in,
  input  logic      si_in,
  output logic      sck_int,
  output sck_edge_t edge_ev,
  output logic      si_bit
);
  logic [CW-1:0] cnt;
  logic [2:0]    sck_sync;
  logic [1:0]    si_sync;
  logic          half_done;

  assign half_done = (cnt == CW'(HALF - 1));

  // internal clock: toggles every HALF cycles, rests high when idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sck_int <= 1'b1;
    end else if (!run || src == SCK_EXTERNAL) begin
      cnt     <= '0;
      sck_int <= 1'b1;
    end else if (gate) begin
      if (half_done) begin
        cnt     <= '0;
        sck_int <= ~sck_int;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // external clock and data: two-flop synchronizers plus edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync <= 3'b111;
      si_sync  <= 2'b00;
    end else begin
      sck_sync <= {sck_sync[1:0], sck_in};
      si_sync  <= {si_sync[0], si_in};
    end
  end

  always_comb begin
    edge_ev = '0;
    if (run && gate) begin
      if (src == SCK_EXTERNAL) begin
        edge_ev.fall = sck_sync[2] & ~sck_sync[1];
        edge_ev.rise = ~sck_sync[2] & sck_sync[1];
      end else begin
        edge_ev.fall = half_done & sck_int;
        edge_ev.rise = half_done & ~sck_int;
      end
    end
  end

  assign si_bit = (src == SCK_EXTERNAL) ? si_sync[1] : si_in;

  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> sck_int);
  assert_one_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(edge_ev.fall && edge_ev.rise));
  assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !gate) |=> $stable(sck_int));
endmodule

// File: rtl/sbp_shifter.sv
module sbp_shifter
  import sbp_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = IW + 1,
  localparam int BW   = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [LW-1:0] n_bytes,
  input  logic [IW-1:0] head_idx,
  input  sck_edge_t     edge_ev,
  input  logic          si_bit,
  input  logic [DW-1:0] acc_data,
  output logic [IW-1:0] acc_idx,
  output logic          upd_en,
  output logic [IW-1:0] upd_idx,
  output logic [DW-1:0] upd_data,
  output logic          busy,
  output logic          done,
  output logic          so
);
  logic [IW-1:0] ptr;
  logic [LW-1:0] left;
  logic [BW-1:0] bitc;
  logic [DW-1:0] tx_sr;
  logic [DW-1:0] rx_sr;
  logic [IW-1:0] ptr_nxt;
  logic          byte_end;

  assign ptr_nxt  = (ptr == IW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  assign acc_idx  = busy ? ptr_nxt : head_idx;
  assign byte_end = busy && edge_ev.rise && (bitc == BW'(DW - 1));
  assign upd_en   = byte_end;
  assign upd_idx  = ptr;
  assign upd_data = {rx_sr[DW-2:0], si_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      ptr   <= '0;
      left  <= '0;
      bitc  <= '0;
      tx_sr <= '0;
      rx_sr <= '0;
      so    <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy  <= 1'b1;
          ptr   <= head_idx;
          left  <= n_bytes;
          bitc  <= '0;
          tx_sr <= acc_data;
        end
      end else begin
        if (edge_ev.fall) begin
          so    <= tx_sr[DW-1];
          tx_sr <= {tx_sr[DW-2:0], 1'b0};
        end
        if (edge_ev.rise) begin
          rx_sr <= {rx_sr[DW-2:0], si_bit};
          bitc  <= bitc + 1'b1;
          if (byte_end) begin
            bitc <= '0;
            if (left == LW'(1)) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              left  <= left - 1'b1;
              ptr   <= ptr_nxt;
              tx_sr <= acc_data;
            end
          end
        end
      end
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_wb_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> busy);
  assert_so_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !edge_ev.fall) |=> $stable(so));
  assert_len_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !edge_ev.rise) |=> $stable(left));
endmodule

// File: rtl/burst_serial_port.sv
module burst_serial_port
  import sbp_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int HALF  = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  input  logic [IW-1:0] cfg_count,
  input  logic          cfg_ext_clk,
  input  logic          cfg_cs_mode,
  input  logic          start,
  output logic          busy,
  output logic          done_irq,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          si,
  output logic          so,
  output logic          so_oe,
  input  logic          cs_n
);
  logic [LW-1:0] level;
  logic [IW-1:0] head_idx, acc_idx, upd_idx;
  logic [DW-1:0] acc_data, upd_data;
  logic          upd_en, go, push_en, pop_en;
  logic [LW-1:0] n_bytes;
  logic [1:0]    cs_sync;
  logic          sel_on, drive, si_bit;
  sck_src_e      src;
  sck_edge_t     edge_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_sync <= 2'b11;
    else        cs_sync <= {cs_sync[0], cs_n};
  end

  assign sel_on   = ~cs_sync[1];
  assign drive    = ~cfg_cs_mode | sel_on;
  assign src      = sck_src_e'(cfg_ext_clk);
  assign go       = start & ~busy;
  assign n_bytes  = (cfg_count == '0) ? LW'(DEPTH) : {1'b0, cfg_count};
  assign wr_ready = ~busy & (level < LW'(DEPTH));
  assign rd_valid = ~busy & ~start & (level != '0);
  assign push_en  = wr_valid & wr_ready;
  assign pop_en   = rd_valid & rd_ready;
  assign sck_oe   = (src == SCK_INTERNAL) & drive;
  assign so_oe    = drive;

  sbp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_en(push_en), .push_data(wr_data),
    .pop_en(pop_en), .head_data(rd_data), .head_idx(head_idx), .level(level),
    .acc_idx(acc_idx), .acc_data(acc_data),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data)
  );

  sbp_sck_gen #(.HALF(HALF)) u_sck (
    .clk(clk), .rst_n(rst_n), .run(busy), .src(src), .gate(drive),
    .sck_in(sck_i), .si_in(si), .sck_int(sck_o), .edge_ev(edge_ev), .si_bit(si_bit)
  );

  sbp_shifter #(.DW(DW), .DEPTH(DEPTH)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(go), .n_bytes(n_bytes), .head_idx(head_idx),
    .edge_ev(edge_ev), .si_bit(si_bit), .acc_data(acc_data), .acc_idx(acc_idx),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data),
    .busy(busy), .done(done_irq), .so(so)
  );

  assert_rd_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !busy);
  assert_wr_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !busy);
  assert_ext_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ext_clk |-> !sck_oe);
endmodule

// File: tb/burst_serial_port_tb.sv
module burst_serial_port_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_valid = 0, rd_ready = 0, start = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] cfg_count = 0;
  logic cfg_ext_clk = 0, cfg_cs_mode = 0;
  logic sck_i = 1, si = 0, cs_n = 1;
  logic wr_ready, rd_valid, busy, done_irq, sck_o, sck_oe, so, so_oe;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  int cyc = 0, last_rise = 0, bi = 0, ri = 0, donecnt = 0;
  bit int_model = 0, per_bad = 0;
  logic [7:0] sl [8];
  logic [7:0] mst [8];
  logic [7:0] cap [8];

  always #10 clk = ~clk;

  burst_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .cfg_count(cfg_count),
    .cfg_ext_clk(cfg_ext_clk), .cfg_cs_mode(cfg_cs_mode), .start(start), .busy(busy),
    .done_irq(done_irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .si(si),
    .so(so), .so_oe(so_oe), .cs_n(cs_n)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && done_irq) donecnt <= donecnt + 1;
  end

  // far-end model for internally clocked bursts
  always @(negedge sck_o) if (int_model && bi < 64) begin
    si <= sl[bi/8][7 - (bi%8)];
    bi++;
  end
  always @(posedge sck_o) if (int_model) begin
    if (ri < 64) cap[ri/8][7 - (ri%8)] = so;
    if (ri > 0 && cyc - last_rise != 16) per_bad = 1;
    last_rise = cyc;
    ri++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    wr_valid = 1; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < 8; i++) begin
      mst[i] = 8'((n*53 + i*29 + 7) & 255);
      sl[i]  = 8'((n*17 + i*101 + 90) & 255);
      cap[i] = 8'h00;
      chk(wr_ready == 1, "R1 ready below depth", int'(wr_ready), 1);
      push(mst[i]);
    end
    chk(wr_ready == 0, "R1 ready low when full", int'(wr_ready), 0);
    bi = 0; ri = 0; per_bad = 0;
  endtask

  task automatic drain(input int n, input string tag);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] exp = (i < n) ? sl[i] : mst[i];
      chk(rd_valid == 1, "R2 read valid", int'(rd_valid), 1);
      chk(rd_data == exp, tag, int'(rd_data), int'(exp));
      rd_ready = 1;
      @(negedge clk);
      rd_ready = 0;
    end
    chk(rd_valid == 0, "R2 empty after drain", int'(rd_valid), 0);
  endtask

  task automatic run_internal(input int n);
    int m;
    fill(n);
    int_model = 1;
    cfg_count = 3'(n % 8);
    start = 1;
    @(posedge clk);
    m = 0;
    forever begin
      @(negedge clk);
      start = (m == 40);
      cfg_count = (m == 40) ? 3'd1 : 3'(n % 8);
      if (m == 20) chk(rd_valid == 0, "R2 no read while busy", int'(rd_valid), 0);
      if (done_irq || m > 2000) break;
      m++;
    end
    start = 0;
    chk(m == 128*n, "R6/R9 completion time", m, 128*n);
    chk(busy == 0, "R6 busy clear with done", int'(busy), 0);
    @(negedge clk);
    chk(done_irq == 0, "R6 single-cycle pulse", int'(done_irq), 0);
    chk(sck_o == 1 && sck_oe == 1, "R5 clock idles high and driven", int'(sck_o), 1);
    chk(!per_bad && ri == 8*n, "R5 period 16 and edge count", ri, 8*n);
    int_model = 0;
    for (int i = 0; i < n; i++)
      chk(cap[i] == mst[i], "R3 transmitted byte msb first", int'(cap[i]), int'(mst[i]));
    drain(n, "R4 write-back and untouched tail");
  endtask

  task automatic run_external(input int n);
    int d0;
    fill(n);
    cfg_ext_clk = 1;
    @(negedge clk);
    chk(sck_oe == 0, "R7 clock output floated", int'(sck_oe), 0);
    cfg_count = 3'(n % 8);
    d0 = donecnt;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R7 armed", int'(busy), 1);
    for (int b = 0; b < 8*n; b++) begin
      sck_i = 0;
      repeat (2) @(negedge clk);
      si = sl[b/8][7 - (b%8)];
      repeat (18) @(negedge clk);
      cap[b/8][7 - (b%8)] = so;
      sck_i = 1;
      repeat (20) @(negedge clk);
    end
    chk(donecnt == d0 + 1 && busy == 0, "R7 burst completes once", donecnt - d0, 1);
    for (int i = 0; i < n; i++)
      chk(cap[i] == mst[i], "R7 transmitted byte", int'(cap[i]), int'(mst[i]));
    drain(n, "R7 received byte in queue");
    cfg_ext_clk = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done_irq == 0, "R6 reset idle", int'(busy), 0);
    chk(sck_o == 1 && sck_oe == 1 && so_oe == 1, "R5 reset clock high", int'(sck_o), 1);
    chk(wr_ready == 1 && rd_valid == 0, "R1/R2 reset queue empty", int'(rd_valid), 0);

    for (int n = 1; n <= 8; n++) run_internal(n);
    run_external(1);
    run_external(3);
    run_external(8);

    // select-gated mode
    cfg_cs_mode = 1; cs_n = 1;
    repeat (3) @(negedge clk);
    chk(sck_oe == 0 && so_oe == 0, "R8 outputs floated while deselected", int'(so_oe), 0);
    fill(2);
    int_model = 1;
    cfg_count = 3'd2;
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (100) @(negedge clk);
    chk(busy == 1 && sck_o == 1 && ri == 0, "R8 no shifting while deselected", ri, 0);
    cs_n = 0;
    repeat (3) @(negedge clk);
    chk(sck_oe == 1 && so_oe == 1, "R8 outputs driven when selected", int'(sck_oe), 1);
    for (int w = 0; w < 600 && busy; w++) @(negedge clk);
    chk(busy == 0 && ri == 16, "R8 burst runs when selected", ri, 16);
    int_model = 0;
    for (int i = 0; i < 2; i++)
      chk(cap[i] == mst[i], "R8 transmitted byte", int'(cap[i]), int'(mst[i]));
    drain(2, "R8 received byte in queue");
    cs_n = 1;
    repeat (3) @(negedge clk);
    chk(sck_oe == 0 && so_oe == 0, "R8 floated after deselect", int'(sck_oe), 0);
    cfg_cs_mode = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule